// File: doc/BRIEF.md
# SPI flash command front-end

This block is the slave-side serial command interface of a small page-erasable flash memory model. It takes the four serial pins (active-low chip select, serial clock, data in, data out with a separate output enable), assembles the incoming bits into an opcode followed by address, dummy and data bytes, and turns each recognised command into work for a back end: read requests that fill an output shift register, staged write requests for page data, and a one-cycle execute pulse for commands that change the array or the device state.

The serial pins are oversampled by the block's own clock through synchronizer stages, so every serial clock high and low phase must last at least 6 cycles of `clk`. The back-end memory port is a single request strobe with a write flag. A read request returns its byte on `mem_rdata` in the cycle after the request. Page data bytes reach the back end as staged writes, one per byte. A page write or page program takes effect only if the execute pulse follows; without it the back end discards the staged bytes. The array sequencing, erase and program algorithms and power behaviour belong to the back end.

Top module: `spi_flash_frontend`

## Requirements
- R1: While `cs_n` is low, `mosi` is sampled on each rising `sclk` edge, most significant bit first; the first 8 bits form the opcode and later bytes follow in the same way.
- R2: Opcode 03h followed by three address bytes (most significant byte first, a 24-bit address) makes `miso` return the array byte at that address, then at each following address (wrapping from FFFFFFh to 000000h), most significant bit first, with each bit changing after a falling `sclk` edge.
- R3: Opcode 0Bh works as 03h except that one dummy byte follows the address before the first data bit.
- R4: Opcode 05h returns `status_in` repeatedly, one value per output byte; each byte's value is taken at the falling edge where that byte's first bit starts.
- R5: Opcode 9Fh returns the bytes of `ID_VALUE`, most significant byte first, then 00h for every later byte.
- R6: A read-class command (03h, 0Bh, 05h, 9Fh) may be ended by `cs_n` going high after any bit; the next transaction is decoded normally.
- R7: After opcode 0Ah or 02h and the three address bytes, each complete data byte produces exactly one write request (`mem_req` and `mem_we` high for one cycle) whose address keeps the upper 16 address bits and takes the low 8 bits from the start address plus the byte's position, wrapping within the 256-byte page.
- R8: The commands 06h, 04h, B9h, ABh (no address), DBh, D8h (three address bytes) and 0Ah, 02h (address plus at least one data byte) raise `exec_valid` for one cycle after `cs_n` goes high, with `exec_code` set to the opcode and `exec_addr` to the received start address; whole extra bytes do not prevent this.
- R9: If the count of `sclk` rising edges in the transaction is not a multiple of 8, or the bytes a command needs were not all received, no execute pulse is given.
- R10: If `busy` is high when the opcode byte completes, an array command (03h, 0Bh, 0Ah, 02h, DBh, D8h) is ignored for the whole transaction: no memory request, no output enable, no execute pulse; 05h, 06h and the other non-array commands still work.
- R11: An opcode outside the set above is ignored until `cs_n` goes high: no request, no output enable, no execute pulse.
- R12: After reset `miso_oe`, `mem_req` and `exec_valid` are low; `miso_oe` is high only while `cs_n` is low during the data-out phase of a read-class command, and `miso` is 0 whenever `miso_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Output enable for `miso` (low stands for high impedance) |
| mem_req | output | 1 | One-cycle memory request strobe |
| mem_we | output | 1 | Request is a staged page write when high, a read when low |
| mem_addr | output | 8*ADDR_BYTES | Request address |
| mem_wdata | output | 8 | Staged write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| status_in | input | 8 | Status value returned by the status read |
| busy | input | 1 | Back end is in a write, program or erase cycle |
| exec_valid | output | 1 | One-cycle pulse: an accepted command is to be carried out |
| exec_code | output | 8 | Opcode of the accepted command |
| exec_addr | output | 8*ADDR_BYTES | Start address of the accepted command |

## Verification
The bench ends write-class transactions one to seven clocks short of or past a byte boundary and after too few address bytes, where a decoder that counted only bytes would issue a stray execute pulse. It starts reads at FFFFFFh and page writes near the end of a page, where a wrong carry would return or stage the wrong byte, and stops reads in the middle of a byte to show the next transaction is not shifted by leftover bits. It raises `busy` before array commands, where a careless design would still touch memory or drive `miso`, and sends an unknown opcode to show nothing is driven.

// File: rtl/spif_pkg.sv
package spif_pkg;

    localparam logic [7:0] OPC_WEN   = 8'h06;
    localparam logic [7:0] OPC_WDIS  = 8'h04;
    localparam logic [7:0] OPC_IDENT = 8'h9F;
    localparam logic [7:0] OPC_STAT  = 8'h05;
    localparam logic [7:0] OPC_RD    = 8'h03;
    localparam logic [7:0] OPC_FRD   = 8'h0B;
    localparam logic [7:0] OPC_PWR   = 8'h0A;
    localparam logic [7:0] OPC_PPG   = 8'h02;
    localparam logic [7:0] OPC_PER   = 8'hDB;
    localparam logic [7:0] OPC_SER   = 8'hD8;
    localparam logic [7:0] OPC_SLEEP = 8'hB9;
    localparam logic [7:0] OPC_WAKE  = 8'hAB;

    // Transaction phase after the opcode byte
    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_DUMMY,
        PH_SEND,
        PH_LOAD,
        PH_TAIL,
        PH_SKIP
    } phase_e;

    // Where outgoing bytes come from
    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_ARRAY,
        SRC_STATUS,
        SRC_IDENT
    } src_e;

    typedef struct packed {
        logic known;
        logic array;
        logic commit;
        logic has_addr;
        logic dummy;
        logic wdata;
        src_e src;
    } opinfo_t;

    function automatic opinfo_t op_lookup(input logic [7:0] c);
        opinfo_t r;
        r = '0;
        r.src = SRC_NONE;
        case (c)
            OPC_WEN, OPC_WDIS, OPC_SLEEP, OPC_WAKE: begin
                r.known  = 1'b1;
                r.commit = 1'b1;
            end
            OPC_IDENT: begin
                r.known = 1'b1;
                r.src   = SRC_IDENT;
            end
            OPC_STAT: begin
                r.known = 1'b1;
                r.src   = SRC_STATUS;
            end
            OPC_RD, OPC_FRD: begin
                r.known    = 1'b1;
                r.array    = 1'b1;
                r.has_addr = 1'b1;
                r.dummy    = (c == OPC_FRD);
                r.src      = SRC_ARRAY;
            end
            OPC_PWR, OPC_PPG: begin
                r.known    = 1'b1;
                r.array    = 1'b1;
                r.has_addr = 1'b1;
                r.commit   = 1'b1;
                r.wdata    = 1'b1;
            end
            OPC_PER, OPC_SER: begin
                r.known    = 1'b1;
                r.array    = 1'b1;
                r.has_addr = 1'b1;
                r.commit   = 1'b1;
            end
            default: ;
        endcase
        return r;
    endfunction

    function automatic logic is_commit_code(input logic [7:0] c);
        return op_lookup(c).commit;
    endfunction

endpackage

// File: rtl/spif_sync.sv
module spif_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic cs_end,
    output logic mosi_s
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sck_p, csn_p, dat_p;
    logic              sck_d, act_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p <= '0;
            csn_p <= '1;
            dat_p <= '0;
            sck_d <= 1'b0;
            act_d <= 1'b0;
        end else begin
            sck_p <= {sck_p[STAGES-2:0], sclk};
            csn_p <= {csn_p[STAGES-2:0], cs_n};
            dat_p <= {dat_p[STAGES-2:0], mosi};
            sck_d <= sck_p[TOP];
            act_d <= ~csn_p[TOP];
        end
    end

    assign sclk_rise = sck_p[TOP] & ~sck_d;
    assign sclk_fall = ~sck_p[TOP] & sck_d;
    assign cs_act    = ~csn_p[TOP];
    assign cs_end    = act_d & ~cs_act;
    assign mosi_s    = dat_p[TOP];

endmodule

// File: rtl/spif_rx.sv
module spif_rx #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             sample,
    input  logic             din,
    output logic             byte_stb,
    output logic [7:0]       byte_val,
    output logic [CNT_W-1:0] byte_no,
    output logic [2:0]       bit_pos
);
    logic [6:0]       sr;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sr       <= '0;
            bit_pos  <= '0;
            cnt      <= '0;
            byte_stb <= 1'b0;
            byte_val <= '0;
            byte_no  <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (sample) begin
                if (bit_pos == 3'd7) begin
                    byte_val <= {sr, din};
                    byte_stb <= 1'b1;
                    byte_no  <= cnt;
                    if (cnt != '1) cnt <= cnt + 1'b1;
                    bit_pos  <= 3'd0;
                end else begin
                    sr      <= {sr[5:0], din};
                    bit_pos <= bit_pos + 3'd1;
                end
            end
        end
    end

endmodule

// File: rtl/spif_tx.sv
module spif_tx (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       enable,
    input  logic       fall,
    input  logic [7:0] load_val,
    output logic       load_take,
    output logic       dout,
    output logic       driving
);
    logic [7:0] sr;
    logic [2:0] cnt;

    assign load_take = enable & fall & (cnt == 3'd0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sr      <= '0;
            cnt     <= '0;
            driving <= 1'b0;
        end else if (enable && fall) begin
            if (cnt == 3'd0) begin
                sr      <= load_val;
                driving <= 1'b1;
            end else begin
                sr <= {sr[6:0], 1'b0};
            end
            cnt <= cnt + 3'd1;
        end
    end

    assign dout = sr[7] & driving;

endmodule

// File: rtl/spi_flash_frontend.sv
module spi_flash_frontend
    import spif_pkg::*;
#(
    parameter int          ADDR_BYTES  = 3,
    parameter int          SYNC_STAGES = 2,
    parameter int          CNT_W       = 4,
    parameter int          ID_BYTES    = 3,
    parameter logic [23:0] ID_VALUE    = 24'hC2_5A_17
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cs_n,
    input  logic                    sclk,
    input  logic                    mosi,
    output logic                    miso,
    output logic                    miso_oe,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [8*ADDR_BYTES-1:0] mem_addr,
    output logic [7:0]              mem_wdata,
    input  logic [7:0]              mem_rdata,
    input  logic [7:0]              status_in,
    input  logic                    busy,
    output logic                    exec_valid,
    output logic [7:0]              exec_code,
    output logic [8*ADDR_BYTES-1:0] exec_addr
);
    localparam int                ADDR_W    = 8 * ADDR_BYTES;
    localparam int                ID_W      = 8 * ID_BYTES;
    localparam int                IDX_W     = $clog2(ID_BYTES + 1);
    localparam logic [CNT_W-1:0]  LAST_ADDR = CNT_W'(ADDR_BYTES);
    localparam logic [IDX_W-1:0]  ID_END    = IDX_W'(ID_BYTES);
    localparam logic [ADDR_W-1:0] ONE_A     = ADDR_W'(1);

    logic             sclk_rise, sclk_fall, cs_act, cs_end, mosi_s;
    logic             rx_stb;
    logic [7:0]       rx_byte;
    logic [CNT_W-1:0] rx_no;
    logic [2:0]       bit_pos;
    logic             load_take, tx_bit, tx_drv;
    logic [7:0]       load_val;

    phase_e              ph;
    opinfo_t             info, dec;
    logic [7:0]          opc;
    logic [ADDR_W-1:0]   base, rd_ptr, addr_next;
    logic [7:0]          wr_lo, pre;
    logic                got_data, fetch_q, commit_ok;
    logic [IDX_W-1:0]    id_idx;
    logic [ID_W-1:0]     id_sh;

    spif_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_act(cs_act), .cs_end(cs_end), .mosi_s(mosi_s)
    );

    spif_rx #(.CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst(rst), .clear(~cs_act),
        .sample(sclk_rise & cs_act), .din(mosi_s),
        .byte_stb(rx_stb), .byte_val(rx_byte), .byte_no(rx_no), .bit_pos(bit_pos)
    );

    spif_tx u_tx (
        .clk(clk), .rst(rst), .clear(~cs_act),
        .enable((ph == PH_SEND) & cs_act), .fall(sclk_fall),
        .load_val(load_val), .load_take(load_take),
        .dout(tx_bit), .driving(tx_drv)
    );

    assign dec       = op_lookup(rx_byte);
    assign addr_next = {base[ADDR_W-9:0], rx_byte};
    assign id_sh     = ID_VALUE[ID_W-1:0] << {id_idx, 3'b000};

    always_comb begin
        case (info.src)
            SRC_STATUS: load_val = status_in;
            SRC_IDENT:  load_val = id_sh[ID_W-1 -: 8];
            SRC_ARRAY:  load_val = pre;
            default:    load_val = 8'h00;
        endcase
    end

    assign miso_oe = tx_drv & cs_act;
    assign miso    = tx_bit & cs_act;

    // Command sequencing
    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            ph        <= PH_OPCODE;
            info      <= '0;
            opc       <= '0;
            base      <= '0;
            rd_ptr    <= '0;
            wr_lo     <= '0;
            got_data  <= 1'b0;
            id_idx    <= '0;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            if (rx_stb) begin
                case (ph)
                    PH_OPCODE: begin
                        opc  <= rx_byte;
                        info <= dec;
                        if (!dec.known || (dec.array && busy)) ph <= PH_SKIP;
                        else if (dec.has_addr)                 ph <= PH_ADDR;
                        else if (dec.src != SRC_NONE)          ph <= PH_SEND;
                        else                                   ph <= PH_TAIL;
                    end
                    PH_ADDR: begin
                        base <= addr_next;
                        if (rx_no == LAST_ADDR) begin
                            wr_lo <= rx_byte;
                            if (info.dummy) begin
                                ph <= PH_DUMMY;
                            end else if (info.src == SRC_ARRAY) begin
                                ph       <= PH_SEND;
                                mem_req  <= 1'b1;
                                mem_addr <= addr_next;
                                rd_ptr   <= addr_next;
                            end else if (info.wdata) begin
                                ph <= PH_LOAD;
                            end else begin
                                ph <= PH_TAIL;
                            end
                        end
                    end
                    PH_DUMMY: begin
                        ph       <= PH_SEND;
                        mem_req  <= 1'b1;
                        mem_addr <= base;
                        rd_ptr   <= base;
                    end
                    PH_LOAD: begin
                        mem_req   <= 1'b1;
                        mem_we    <= 1'b1;
                        mem_addr  <= {base[ADDR_W-1:8], wr_lo};
                        mem_wdata <= rx_byte;
                        wr_lo     <= wr_lo + 8'd1;
                        got_data  <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (load_take) begin
                if (info.src == SRC_ARRAY) begin
                    rd_ptr   <= rd_ptr + ONE_A;
                    mem_req  <= 1'b1;
                    mem_we   <= 1'b0;
                    mem_addr <= rd_ptr + ONE_A;
                end
                if (info.src == SRC_IDENT && id_idx != ID_END) id_idx <= id_idx + 1'b1;
            end
        end
    end

    // Prefetched array byte
    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_q <= 1'b0;
            pre     <= '0;
        end else begin
            fetch_q <= mem_req & ~mem_we;
            if (fetch_q) pre <= mem_rdata;
        end
    end

    // Acceptance at deselect
    assign commit_ok = info.commit && (bit_pos == 3'd0) &&
                       ((ph == PH_TAIL) || (ph == PH_LOAD && got_data));

    always_ff @(posedge clk) begin
        if (rst) begin
            exec_valid <= 1'b0;
            exec_code  <= '0;
            exec_addr  <= '0;
        end else begin
            exec_valid <= cs_end & commit_ok;
            if (cs_end && commit_ok) begin
                exec_code <= opc;
                exec_addr <= base;
            end
        end
    end

endmodule

// File: rtl/spif_checker.sv
module spif_checker (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       miso_oe,
    input logic       mem_req,
    input logic       mem_we,
    input logic       exec_valid,
    input logic [7:0] exec_code
);
    import spif_pkg::*;

    // R12: no output drive once chip select has been high for several cycles
    p_quiet_deselected_r12: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso_oe);

    // R12: never stage a write while read data is driven
    p_no_write_in_read_r12: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && mem_we && miso_oe));

    // R8: execute pulses only carry write-class opcodes
    p_exec_code_r8: assert property (@(posedge clk) disable iff (rst)
        exec_valid |-> is_commit_code(exec_code));

    // R8: execute is a single-cycle pulse
    p_exec_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        exec_valid |=> !exec_valid);

    // R7: one request per byte, never back to back
    p_req_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R9: acceptance only follows deselection
    p_exec_deselected_r9: assert property (@(posedge clk) disable iff (rst)
        exec_valid |-> cs_n);

endmodule

bind spi_flash_frontend spif_checker u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .miso_oe(miso_oe),
    .mem_req(mem_req), .mem_we(mem_we),
    .exec_valid(exec_valid), .exec_code(exec_code)
);

// File: tb/spi_flash_frontend_tb.sv
module spi_flash_frontend_tb;

    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic        miso, miso_oe, mem_req, mem_we, exec_valid, busy = 1'b0;
    logic [23:0] mem_addr, exec_addr;
    logic [7:0]  mem_wdata, mem_rdata = 8'h00, status_in = 8'h00, exec_code;

    int n_chk = 0, n_fail = 0;
    int exec_n = 0, wr_n = 0, rd_n = 0;
    logic [7:0]  last_code;
    logic [23:0] last_addr;
    logic [23:0] wlog_a [0:15];
    logic [7:0]  wlog_d [0:15];
    logic [7:0]  seq [0:7];

    always #2.5 clk = ~clk;

    spi_flash_frontend u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .status_in(status_in), .busy(busy), .exec_valid(exec_valid),
        .exec_code(exec_code), .exec_addr(exec_addr)
    );

    function automatic logic [7:0] arr_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h5A;
    endfunction

    // Back-end model and monitors
    always @(posedge clk) begin
        if (mem_req && !mem_we) begin
            mem_rdata <= arr_byte(mem_addr);
            rd_n <= rd_n + 1;
        end
        if (mem_req && mem_we) begin
            wlog_a[wr_n % 16] <= mem_addr;
            wlog_d[wr_n % 16] <= mem_wdata;
            wr_n <= wr_n + 1;
        end
        if (exec_valid) begin
            exec_n    <= exec_n + 1;
            last_code <= exec_code;
            last_addr <= exec_addr;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic desel();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(14);
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < nb; i++) begin
            mosi = tx[7-i];
            wait_clk(HALF);
            rx[7-i] = miso;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, 8, rx);
    endtask

    task automatic do_read(input logic fast, input logic [23:0] a, input int n, input string tag);
        logic [7:0] r;
        logic [23:0] ak;
        sel();
        xfer(fast ? 8'h0B : 8'h03, r);
        xfer(a[23:16], r);
        xfer(a[15:8], r);
        xfer(a[7:0], r);
        if (fast) xfer(8'hC3, r);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, r);
            ak = a + 24'(k);
            chk(tag, {24'h0, r}, {24'h0, arr_byte(ak)});
        end
        desel();
    endtask

    // Sends whole bytes from seq, then extra bits of one more byte
    task automatic send_seq(input int nb, input int extra);
        logic [7:0] r;
        sel();
        for (int i = 0; i < nb; i++) xfer(seq[i], r);
        if (extra > 0) xfer_bits(8'hA5, extra, r);
        desel();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] r;
        int e0, w0, q0;
        void'($urandom(32'd4711));
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);

        // R12 reset state
        chk("R12 reset oe", {31'h0, miso_oe}, 0);
        chk("R12 reset req", {31'h0, mem_req}, 0);
        chk("R12 reset exec", {31'h0, exec_valid}, 0);

        // R1 R2 read crossing low-byte carry, then top-of-space wrap
        do_read(1'b0, 24'h1234FE, 4, "R1 R2 read carry");
        do_read(1'b0, 24'hFFFFFF, 2, "R2 read wrap");
        // R3 fast read
        do_read(1'b1, 24'h00A0FF, 3, "R3 fast read");

        // R4 status read, value taken per byte
        status_in = 8'hA5;
        sel();
        xfer(8'h05, r);
        xfer(8'h00, r);
        chk("R4 status byte0", {24'h0, r}, 32'hA5);
        status_in = 8'h3C;
        chk("R12 oe during read", {31'h0, miso_oe}, 1);
        xfer(8'h00, r);
        chk("R4 status byte1", {24'h0, r}, 32'h3C);
        desel();
        chk("R12 oe after deselect", {31'h0, miso_oe}, 0);

        // R5 identification
        sel();
        xfer(8'h9F, r);
        xfer(8'h00, r); chk("R5 id0", {24'h0, r}, 32'hC2);
        xfer(8'h00, r); chk("R5 id1", {24'h0, r}, 32'h5A);
        xfer(8'h00, r); chk("R5 id2", {24'h0, r}, 32'h17);
        xfer(8'h00, r); chk("R5 id pad", {24'h0, r}, 32'h00);
        desel();

        // R6 read cut mid-byte, next read unaffected
        sel();
        xfer(8'h03, r); xfer(8'h00, r); xfer(8'h10, r); xfer(8'h20, r);
        xfer_bits(8'h00, 3, r);
        desel();
        do_read(1'b0, 24'h001020, 2, "R6 read after cut");

        // R8 R9 write enable alignment
        seq[0] = 8'h06; seq[1] = 8'h00;
        e0 = exec_n; send_seq(1, 0);
        chk("R8 wren count", exec_n - e0, 1);
        chk("R8 wren code", {24'h0, last_code}, 32'h06);
        e0 = exec_n; send_seq(1, 1);
        chk("R9 wren 9 clocks", exec_n - e0, 0);
        e0 = exec_n; send_seq(2, 0);
        chk("R8 wren extra byte", exec_n - e0, 1);

        // R7 R8 page program wrapping in page
        seq[0] = 8'h02; seq[1] = 8'h01; seq[2] = 8'h00; seq[3] = 8'hFE;
        seq[4] = 8'h11; seq[5] = 8'h22; seq[6] = 8'h33;
        e0 = exec_n; w0 = wr_n; send_seq(7, 0);
        chk("R7 write count", wr_n - w0, 3);
        chk("R7 wr0 addr", {8'h0, wlog_a[w0 % 16]}, 32'h0100FE);
        chk("R7 wr1 addr", {8'h0, wlog_a[(w0+1) % 16]}, 32'h0100FF);
        chk("R7 wr2 addr wrap", {8'h0, wlog_a[(w0+2) % 16]}, 32'h010000);
        chk("R7 wr2 data", {24'h0, wlog_d[(w0+2) % 16]}, 32'h33);
        chk("R8 pp exec", exec_n - e0, 1);
        chk("R8 pp code", {24'h0, last_code}, 32'h02);
        chk("R8 pp addr", {8'h0, last_addr}, 32'h0100FE);
        seq[0] = 8'h0A;
        e0 = exec_n; send_seq(5, 3);
        chk("R9 pw misaligned", exec_n - e0, 0);
        e0 = exec_n; send_seq(4, 0);
        chk("R9 pw no data", exec_n - e0, 0);

        // R8 R9 erase
        seq[0] = 8'hD8; seq[1] = 8'h07; seq[2] = 8'h80; seq[3] = 8'h00;
        e0 = exec_n; send_seq(4, 0);
        chk("R8 se exec", exec_n - e0, 1);
        chk("R8 se addr", {8'h0, last_addr}, 32'h078000);
        seq[0] = 8'hDB;
        e0 = exec_n; send_seq(3, 0);
        chk("R9 pe short addr", exec_n - e0, 0);

        // R10 busy
        busy = 1'b1;
        q0 = rd_n;
        sel();
        xfer(8'h03, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h40, r);
        xfer(8'h00, r);
        chk("R10 busy read oe", {31'h0, miso_oe}, 0);
        chk("R10 busy read data", {24'h0, r}, 0);
        desel();
        chk("R10 busy no fetch", rd_n - q0, 0);
        seq[0] = 8'h02; seq[1] = 8'h00; seq[2] = 8'h00; seq[3] = 8'h10; seq[4] = 8'h99;
        e0 = exec_n; w0 = wr_n; send_seq(5, 0);
        chk("R10 busy pp writes", wr_n - w0, 0);
        chk("R10 busy pp exec", exec_n - e0, 0);
        status_in = 8'h01;
        sel(); xfer(8'h05, r); xfer(8'h00, r); desel();
        chk("R10 status while busy", {24'h0, r}, 32'h01);
        seq[0] = 8'h04;
        e0 = exec_n; send_seq(1, 0);
        chk("R10 wrdi while busy", exec_n - e0, 1);
        busy = 1'b0;

        // R11 unknown opcode
        seq[0] = 8'h77; seq[1] = 8'h12; seq[2] = 8'h34; seq[3] = 8'h56;
        e0 = exec_n; w0 = wr_n; q0 = rd_n;
        sel();
        for (int i = 0; i < 4; i++) xfer(seq[i], r);
        xfer(8'h00, r);
        chk("R11 unknown oe", {31'h0, miso_oe}, 0);
        desel();
        chk("R11 unknown exec", exec_n - e0, 0);
        chk("R11 unknown req", (wr_n - w0) + (rd_n - q0), 0);
        seq[0] = 8'hB9;
        e0 = exec_n; send_seq(1, 0);
        chk("R8 sleep", {24'h0, last_code}, 32'hB9);
        seq[0] = 8'hAB;
        send_seq(1, 0);
        chk("R8 wake count", exec_n - e0, 2);

        // Random mix
        for (int it = 0; it < 30; it++) begin
            int mode, bits;
            logic [23:0] a;
            mode = $urandom % 3;
            a = 24'($urandom);
            if (mode < 2) begin
                do_read(mode == 1, a, 1 + ($urandom % 3), "R2 R3 random read");
            end else begin
                bits = 8 + ($urandom % 36);
                seq[0] = 8'hD8; seq[1] = a[23:16]; seq[2] = a[15:8]; seq[3] = a[7:0];
                seq[4] = 8'h00; seq[5] = 8'h00;
                e0 = exec_n;
                send_seq(bits / 8, bits % 8);
                chk("R8 R9 random erase", exec_n - e0,
                    ((bits % 8 == 0) && bits >= 32) ? 1 : 0);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule